// File: doc/BRIEF.md
# Debug Breakpoint and Halt Controller

This block holds the control and status state of an on-chip debug controller. It decides when the CPU must stop running the user program and enter a halted background mode, where it waits for debug commands from a host. A host-loaded match register is compared against the CPU address bus on every cycle. When software allows it, a match leads to a halt in one of two ways.

The first is the force style. Any address match, on data or on code, arms a request, and the CPU halts at the next instruction boundary. The second is the tag style. Only an opcode fetched from the matching address is marked, and a small tag queue follows it through the CPU's instruction queue. The CPU halts instead of executing that opcode only when it reaches the end of the queue. A queue flush, such as a taken branch, discards the tag.

A host background command halts the CPU at once, and wakes it if it sits in wait or stop. A host go command releases the CPU and re-arms the breakpoint logic. A global enable bit gates all of this. Once set, the enable bit is cleared only by reset.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset, `ctrl_status` reads 0x00, `halted` is 0, `match_value` is 0 and no halt is armed or tagged.
- R2: A write on `host_ctrl_wr` takes effect on the next cycle. Bits 5 (breakpoint enable), 4 (style: 1 force, 0 tag) and 3 (clock select) take the written value. Writing 1 to bit 7 (enable) sets it. Writing 0 to bit 7 leaves it unchanged, so only reset clears it. Bits 6, 2, 1 and 0 are not writable, and bits 1 and 0 always read 0.
- R3: Bit 2 of `ctrl_status` equals `cpu_waitstop` in the same cycle, with no register delay.
- R4: `host_match_wr` loads `host_match_data` into the 16-bit match register. The new value appears on `match_value` on the next cycle.
- R5: While bit 5 is 0, an address equal to the match register neither arms a halt nor tags an opcode, whatever the value of bit 4.
- R6: With bits 7, 5 and 4 set, a match in cycle t while running arms a halt. `halt_pulse` rises in the first later cycle that has `cpu_boundary`, with `halt_cause` = 2. A boundary in cycle t itself does not fire that match. The match does not need `cpu_fetch`.
- R7: With bits 7 and 5 set and bit 4 clear, a `cpu_fetch` whose address matches pushes a tagged entry into a first-in first-out tag queue of QDEPTH entries. Any other fetch pushes an untagged entry, and a fetch into a full queue is dropped. `cpu_retire` pops the oldest entry. Popping a tagged entry gives `halt_pulse` in that cycle, with `halt_cause` = 3.
- R8: `cpu_flush` empties the tag queue, and a fetch in the same cycle is dropped. A tagged opcode that was flushed never causes a halt.
- R9: With bit 7 set and the CPU running, `host_bgnd` gives `halt_pulse` in the same cycle with `halt_cause` = 1. `cpu_wake` is 1 in that cycle exactly when `cpu_waitstop` is also 1.
- R10: While bit 7 is 0, `halt_pulse` stays 0 whatever the inputs.
- R11: `halted` and status bit 6 become 1 on the cycle after `halt_pulse`. While halted, `halt_pulse` stays 0 and matches neither arm nor tag.
- R12: `host_go` while halted clears `halted` on the next cycle. It drops any armed halt, empties the tag queue and leaves bit 7 set. `host_go` while running has no effect.
- R13: When several halt sources are present in one cycle, `halt_cause` takes the command (1) first, then force (2), then tag (3). `halt_cause` is 0 when `halt_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high normal reset |
| host_ctrl_wr | input | 1 | Control register write strobe |
| host_ctrl_data | input | 8 | Control register write data |
| host_match_wr | input | 1 | Match register write strobe |
| host_match_data | input | 16 | Match register write data |
| host_bgnd | input | 1 | Host background (halt) command |
| host_go | input | 1 | Host go/resume command |
| cpu_addr | input | 16 | CPU address bus |
| cpu_fetch | input | 1 | Opcode fetch into instruction queue this cycle |
| cpu_boundary | input | 1 | Instruction boundary this cycle |
| cpu_retire | input | 1 | Oldest queued opcode reaches execution this cycle |
| cpu_flush | input | 1 | Instruction queue flushed this cycle |
| cpu_waitstop | input | 1 | CPU is in wait or stop mode |
| ctrl_status | output | 8 | Control and status register read value |
| match_value | output | 16 | Match register read value |
| halted | output | 1 | CPU held in background mode |
| halt_pulse | output | 1 | One-cycle halt entry event |
| halt_cause | output | 2 | Source of the halt: 0 none, 1 command, 2 force, 3 tag |
| cpu_wake | output | 1 | Wake request for a CPU in wait or stop |

## Verification
Directed sequences cover each path on its own. A force match followed by a later boundary separates force arming from boundary timing. A tagged fetch placed behind an untagged one shows that the halt follows queue order and not the match cycle. A tagged fetch followed by a flush shows that the tag is discarded. A command sent with the CPU in wait or stop proves the wake, and the same command with enable clear proves the gate. Random traffic then mixes addresses that hit the match register often with fetches, retires, flushes, boundaries, control rewrites and go commands, so all sources collide and the priority order and the sticky enable are exercised.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

    localparam int STAT_W  = 8;
    localparam int BIT_EN  = 7;
    localparam int BIT_ACT = 6;
    localparam int BIT_BKP = 5;
    localparam int BIT_FTS = 4;
    localparam int BIT_CLK = 3;
    localparam int BIT_WS  = 2;

    typedef struct packed {
        logic enable;
        logic bkpt_en;
        logic force_sel;
        logic clk_sel;
    } ctrl_t;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_CMD   = 2'd1,
        CAUSE_FORCE = 2'd2,
        CAUSE_TAG   = 2'd3
    } halt_cause_e;

    function automatic logic [STAT_W-1:0] pack_status(ctrl_t c, logic active, logic ws);
        logic [STAT_W-1:0] s;
        s          = '0;
        s[BIT_EN]  = c.enable;
        s[BIT_ACT] = active;
        s[BIT_BKP] = c.bkpt_en;
        s[BIT_FTS] = c.force_sel;
        s[BIT_CLK] = c.clk_sel;
        s[BIT_WS]  = ws;
        return s;
    endfunction

    function automatic halt_cause_e pick_cause(logic cmd, logic frc, logic tag);
        if (cmd)      return CAUSE_CMD;
        else if (frc) return CAUSE_FORCE;
        else if (tag) return CAUSE_TAG;
        else          return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
    import dbg_halt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    input  logic              halted,
    input  logic              waitstop,
    output ctrl_t             ctrl,
    output logic [STAT_W-1:0] status
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr) begin
            ctrl.enable    <= ctrl.enable | wdata[BIT_EN];
            ctrl.bkpt_en   <= wdata[BIT_BKP];
            ctrl.force_sel <= wdata[BIT_FTS];
            ctrl.clk_sel   <= wdata[BIT_CLK];
        end
    end

    assign status = pack_status(ctrl, halted, waitstop);

    AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (rst)
        ctrl.enable |=> ctrl.enable); // R2

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        status[1:0] == 2'b00); // R2

endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
    import dbg_halt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              match_wr,
    input  logic [ADDR_W-1:0] match_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic              fetch,
    input  logic              boundary,
    input  logic              retire,
    input  logic              flush,
    input  ctrl_t             ctrl,
    input  logic              halted,
    input  logic              clear,
    input  logic              fire,
    output logic [ADDR_W-1:0] match_value,
    output logic              force_hit,
    output logic              tag_hit
);

    localparam int CNT_W = $clog2(QDEPTH + 1);

    logic [ADDR_W-1:0] match_q;
    logic              armed;
    logic [QDEPTH-1:0] tag_q, tag_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic              match_now, arm_set, tag_new, queue_nonempty;

    assign match_now      = ctrl.bkpt_en && (addr == match_q);
    assign arm_set        = ctrl.enable && ctrl.force_sel && match_now && !halted;
    assign tag_new        = ctrl.enable && !ctrl.force_sel && match_now && !halted;
    assign queue_nonempty = (cnt != '0);

    assign force_hit   = armed && boundary;
    assign tag_hit     = retire && queue_nonempty && tag_q[0];
    assign match_value = match_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
        end else if (match_wr) begin
            match_q <= match_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (clear || fire) begin
            armed <= 1'b0;
        end else if (arm_set) begin
            armed <= 1'b1;
        end
    end

    always_comb begin
        tag_n = tag_q;
        cnt_n = cnt;
        if (flush || clear) begin
            tag_n = '0;
            cnt_n = '0;
        end else begin
            if (retire && queue_nonempty) begin
                tag_n = tag_q >> 1;
                cnt_n = cnt - 1'b1;
            end
            if (fetch && (cnt_n < CNT_W'(QDEPTH))) begin
                for (int i = 0; i < QDEPTH; i++) begin
                    if (CNT_W'(i) == cnt_n) begin
                        tag_n[i] = tag_new;
                    end
                end
                cnt_n = cnt_n + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
            cnt   <= '0;
        end else begin
            tag_q <= tag_n;
            cnt   <= cnt_n;
        end
    end

    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(QDEPTH)); // R7

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt == '0)); // R8

    AST_NO_ARM_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.bkpt_en && !armed) |=> !armed); // R5

    AST_CLEAR_DISARMS: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!armed && cnt == '0)); // R12

endmodule

// File: rtl/dbg_halt_fsm.sv
module dbg_halt_fsm
    import dbg_halt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        bgnd,
    input  logic        go,
    input  logic        force_hit,
    input  logic        tag_hit,
    input  logic        waitstop,
    output logic        halted,
    output logic        pulse,
    output halt_cause_e cause,
    output logic        wake,
    output logic        go_act
);

    logic cmd_req, frc_req, tag_req;

    assign cmd_req = enable && !halted && bgnd;
    assign frc_req = enable && !halted && force_hit;
    assign tag_req = enable && !halted && tag_hit;

    assign pulse  = cmd_req || frc_req || tag_req;
    assign cause  = pick_cause(cmd_req, frc_req, tag_req);
    assign wake   = cmd_req && waitstop;
    assign go_act = go && halted;

    always_ff @(posedge clk) begin
        if (rst) begin
            halted <= 1'b0;
        end else if (go_act) begin
            halted <= 1'b0;
        end else if (pulse) begin
            halted <= 1'b1;
        end
    end

    AST_PULSE_SETS_HALT: assert property (@(posedge clk) disable iff (rst)
        pulse |=> halted); // R11

    AST_GO_RELEASES: assert property (@(posedge clk) disable iff (rst)
        go_act |=> !halted); // R12

    AST_NO_HALT_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !pulse); // R10

    AST_CMD_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
        (bgnd && enable && !halted) |-> (pulse && cause == CAUSE_CMD)); // R9

    AST_WAKE_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
        wake |-> (pulse && waitstop)); // R9

    AST_NO_PULSE_HALTED: assert property (@(posedge clk) disable iff (rst)
        halted |-> !pulse); // R11

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_ctrl_wr,
    input  logic [7:0]        host_ctrl_data,
    input  logic              host_match_wr,
    input  logic [ADDR_W-1:0] host_match_data,
    input  logic              host_bgnd,
    input  logic              host_go,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_fetch,
    input  logic              cpu_boundary,
    input  logic              cpu_retire,
    input  logic              cpu_flush,
    input  logic              cpu_waitstop,
    output logic [7:0]        ctrl_status,
    output logic [ADDR_W-1:0] match_value,
    output logic              halted,
    output logic              halt_pulse,
    output logic [1:0]        halt_cause,
    output logic              cpu_wake
);

    ctrl_t       ctrl;
    logic        force_hit, tag_hit, go_act;
    halt_cause_e cause;

    dbg_ctrl_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr       (host_ctrl_wr),
        .wdata    (host_ctrl_data),
        .halted   (halted),
        .waitstop (cpu_waitstop),
        .ctrl     (ctrl),
        .status   (ctrl_status)
    );

    dbg_bkpt_unit #(
        .ADDR_W (ADDR_W),
        .QDEPTH (QDEPTH)
    ) u_bkpt (
        .clk         (clk),
        .rst         (rst),
        .match_wr    (host_match_wr),
        .match_data  (host_match_data),
        .addr        (cpu_addr),
        .fetch       (cpu_fetch),
        .boundary    (cpu_boundary),
        .retire      (cpu_retire),
        .flush       (cpu_flush),
        .ctrl        (ctrl),
        .halted      (halted),
        .clear       (go_act),
        .fire        (halt_pulse),
        .match_value (match_value),
        .force_hit   (force_hit),
        .tag_hit     (tag_hit)
    );

    dbg_halt_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .enable    (ctrl.enable),
        .bgnd      (host_bgnd),
        .go        (host_go),
        .force_hit (force_hit),
        .tag_hit   (tag_hit),
        .waitstop  (cpu_waitstop),
        .halted    (halted),
        .pulse     (halt_pulse),
        .cause     (cause),
        .wake      (cpu_wake),
        .go_act    (go_act)
    );

    assign halt_cause = cause;

    AST_STATUS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        ctrl_status[6] == halted); // R11

    AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !halt_pulse |-> (halt_cause == 2'd0)); // R13

endmodule

// File: tb/tb_dbg_halt_ctrl.sv
module tb_dbg_halt_ctrl;

    localparam int QD = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_ctrl_wr, host_match_wr, host_bgnd, host_go;
    logic [7:0]  host_ctrl_data;
    logic [15:0] host_match_data, cpu_addr;
    logic        cpu_fetch, cpu_boundary, cpu_retire, cpu_flush, cpu_waitstop;
    logic [7:0]  ctrl_status;
    logic [15:0] match_value;
    logic        halted, halt_pulse, cpu_wake;
    logic [1:0]  halt_cause;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state, built from the requirements
    bit          m_en, m_bk, m_fts, m_ck, m_hal, m_arm;
    logic [15:0] m_mreg;
    bit          m_q [QD];
    int          m_cnt;
    // expected outputs of the current cycle
    bit          e_pulse, e_wake;
    logic [1:0]  e_cause;

    always #2.5 clk = ~clk;

    dbg_halt_ctrl #(.ADDR_W(16), .QDEPTH(QD)) dut (
        .clk(clk), .rst(rst),
        .host_ctrl_wr(host_ctrl_wr), .host_ctrl_data(host_ctrl_data),
        .host_match_wr(host_match_wr), .host_match_data(host_match_data),
        .host_bgnd(host_bgnd), .host_go(host_go),
        .cpu_addr(cpu_addr), .cpu_fetch(cpu_fetch), .cpu_boundary(cpu_boundary),
        .cpu_retire(cpu_retire), .cpu_flush(cpu_flush), .cpu_waitstop(cpu_waitstop),
        .ctrl_status(ctrl_status), .match_value(match_value), .halted(halted),
        .halt_pulse(halt_pulse), .halt_cause(halt_cause), .cpu_wake(cpu_wake)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {m_en, m_hal, m_bk, m_fts, m_ck, cpu_waitstop, 2'b00};
    endfunction

    task automatic idle();
        host_ctrl_wr = 0; host_ctrl_data = 0; host_match_wr = 0; host_match_data = 0;
        host_bgnd = 0; host_go = 0; cpu_addr = 16'hFFFF; cpu_fetch = 0;
        cpu_boundary = 0; cpu_retire = 0; cpu_flush = 0; cpu_waitstop = 0; rst = 0;
    endtask

    task automatic model_reset();
        m_en = 0; m_bk = 0; m_fts = 0; m_ck = 0; m_hal = 0; m_arm = 0;
        m_mreg = 0; m_cnt = 0;
        for (int i = 0; i < QD; i++) m_q[i] = 0;
    endtask

    // compute expected outputs for the current inputs and compare
    task automatic settle();
        bit frc, tg, cmd;
        #1;
        cmd = m_en && !m_hal && host_bgnd;
        frc = m_en && !m_hal && m_arm && cpu_boundary;
        tg  = m_en && !m_hal && cpu_retire && (m_cnt > 0) && m_q[0];
        e_pulse = cmd || frc || tg;
        e_cause = cmd ? 2'd1 : frc ? 2'd2 : tg ? 2'd3 : 2'd0;
        e_wake  = cmd && cpu_waitstop;
        chk("R11 halted", halted, m_hal);
        chk("R2 R3 status", ctrl_status, exp_status());
        chk("R4 match_value", match_value, m_mreg);
        chk("R6 R7 R9 halt_pulse", halt_pulse, e_pulse);
        chk("R13 halt_cause", halt_cause, e_cause);
        chk("R9 cpu_wake", cpu_wake, e_wake);
    endtask

    // update the reference state at the clock edge, then wait for the next drive point
    task automatic advance();
        bit match, go_act, tag_new, pop;
        int c;
        match   = m_bk && (cpu_addr == m_mreg);
        go_act  = host_go && m_hal;
        tag_new = m_en && match && !m_fts && !m_hal;
        @(posedge clk);
        if (rst) begin
            model_reset();
        end else begin
            if (go_act || e_pulse) m_arm = 0;
            else if (m_en && m_fts && match && !m_hal) m_arm = 1;
            if (cpu_flush || go_act) begin
                m_cnt = 0;
                for (int i = 0; i < QD; i++) m_q[i] = 0;
            end else begin
                pop = cpu_retire && (m_cnt > 0);
                if (pop) begin
                    for (int i = 0; i < QD - 1; i++) m_q[i] = m_q[i+1];
                    m_q[QD-1] = 0;
                end
                c = m_cnt - (pop ? 1 : 0);
                if (cpu_fetch && c < QD) begin
                    m_q[c] = tag_new;
                    c++;
                end
                m_cnt = c;
            end
            if (go_act) m_hal = 0;
            else if (e_pulse) m_hal = 1;
            if (host_ctrl_wr) begin
                m_en  = m_en | host_ctrl_data[7];
                m_bk  = host_ctrl_data[5];
                m_fts = host_ctrl_data[4];
                m_ck  = host_ctrl_data[3];
            end
            if (host_match_wr) m_mreg = host_match_data;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic cyc();
        settle();
        advance();
    endtask

    task automatic wr_ctrl(logic [7:0] d);
        host_ctrl_wr = 1; host_ctrl_data = d;
        cyc();
    endtask

    task automatic do_reset();
        rst = 1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        model_reset();
        idle();
    endtask

    initial begin
        for (int n = 0; n < 200000; n++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        idle();
        @(negedge clk);
        do_reset();

        // R1 reset state
        settle();
        chk("R1 status", ctrl_status, 8'h00);
        chk("R1 halted", halted, 1'b0);
        chk("R1 match_value", match_value, 16'h0000);
        advance();

        // R10 background command ignored while enable is clear
        host_bgnd = 1;
        settle();
        chk("R10 no pulse", halt_pulse, 1'b0);
        advance();

        // R2 writable bits and sticky enable
        wr_ctrl(8'hFF);
        settle(); chk("R2 write all", ctrl_status, 8'hB8); advance();
        wr_ctrl(8'h00);
        settle(); chk("R2 enable sticky", ctrl_status, 8'h80); advance();

        // R3 live wait/stop status
        cpu_waitstop = 1;
        settle(); chk("R3 ws bit", ctrl_status[2], 1'b1); advance();

        // R4 match register load
        host_match_wr = 1; host_match_data = 16'h1234; cyc();
        settle(); chk("R4 loaded", match_value, 16'h1234); advance();

        // R5 matches ignored with breakpoint disabled (force style selected)
        wr_ctrl(8'h90);
        cpu_addr = 16'h1234; cpu_fetch = 1; cyc();
        cpu_boundary = 1; cpu_retire = 1;
        settle(); chk("R5 no force", halt_pulse, 1'b0); advance();

        // R6 force style: match without fetch, boundary in a later cycle
        wr_ctrl(8'hB0);
        cpu_addr = 16'h1234; cpu_boundary = 1;
        settle(); chk("R6 same-cycle boundary", halt_pulse, 1'b0); advance();
        cyc();
        cpu_boundary = 1;
        settle();
        chk("R6 pulse", halt_pulse, 1'b1);
        chk("R6 cause", halt_cause, 2'd2);
        advance();
        settle(); chk("R11 halted", halted, 1'b1); chk("R11 status bit6", ctrl_status[6], 1'b1); advance();

        // R12 go releases, enable kept
        host_go = 1; cyc();
        settle(); chk("R12 released", halted, 1'b0); chk("R12 enable kept", ctrl_status[7], 1'b1); advance();

        // R7 tag style: untagged entry ahead of the tagged one
        wr_ctrl(8'hA0);
        cpu_fetch = 1; cpu_addr = 16'h0100; cyc();
        cpu_fetch = 1; cpu_addr = 16'h1234; cyc();
        cpu_retire = 1;
        settle(); chk("R7 untagged retire", halt_pulse, 1'b0); advance();
        cpu_retire = 1;
        settle(); chk("R7 tagged retire", halt_pulse, 1'b1); chk("R7 cause", halt_cause, 2'd3); advance();
        host_go = 1; cyc();

        // R8 flush drops the tag
        cpu_fetch = 1; cpu_addr = 16'h1234; cyc();
        cpu_flush = 1; cyc();
        cpu_retire = 1;
        settle(); chk("R8 flushed tag", halt_pulse, 1'b0); advance();

        // R9 background command wakes from wait/stop
        host_bgnd = 1; cpu_waitstop = 1;
        settle(); chk("R9 pulse", halt_pulse, 1'b1); chk("R9 wake", cpu_wake, 1'b1); advance();
        host_go = 1; cyc();

        // R13 command beats force in the same cycle
        wr_ctrl(8'hB0);
        cpu_addr = 16'h1234; cyc();
        host_bgnd = 1; cpu_boundary = 1;
        settle(); chk("R13 priority", halt_cause, 2'd1); advance();
        host_go = 1; cyc();
        // R12 go while running is ignored
        host_go = 1;
        settle(); chk("R12 go ignored", halted, 1'b0); advance();

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int r;
            if ($urandom_range(0, 999) == 0) begin
                do_reset();
                continue;
            end
            host_ctrl_wr   = ($urandom_range(0, 15) == 0);
            host_ctrl_data = 8'($urandom());
            if ($urandom_range(0, 3) != 0) host_ctrl_data[7] = 1'b1;
            host_match_wr  = ($urandom_range(0, 31) == 0);
            r = $urandom_range(0, 2);
            host_match_data = (r == 0) ? 16'h1000 : (r == 1) ? 16'h1004 : 16'($urandom());
            cpu_addr     = ($urandom_range(0, 2) == 0) ? m_mreg : 16'($urandom());
            cpu_fetch    = ($urandom_range(0, 1) == 0);
            cpu_boundary = ($urandom_range(0, 2) == 0);
            cpu_retire   = ($urandom_range(0, 2) == 0);
            cpu_flush    = ($urandom_range(0, 15) == 0);
            cpu_waitstop = ($urandom_range(0, 7) == 0);
            host_bgnd    = ($urandom_range(0, 39) == 0);
            host_go      = ($urandom_range(0, 5) == 0);
            cyc();
        end

        finish_run();
    end

endmodule